// File: doc/BRIEF.md
# Translated Address Bit Predictor

This block lets an operand cache access begin before address translation has finished. Two of the bits that index the cache come out of translation. A history table holds a guess for those two bits. In the address-add cycle, the block picks a general-register value: the base register if the request names one, otherwise the index register. A slice of that value addresses the table, and the guess read from it is registered for the cache-access cycle.

In the cache-access cycle the translation buffer supplies the real bits. The block compares them with the guess. When they agree, the raw cache hit passes through. When they differ, the hit is blocked, the table entry is overwritten with the real bits, and a recycle request is raised one cycle later. That request carries the correct bits and the table slot. Two saturating counters tally verified good and bad guesses. Only operand requests use this block.

Top module: `xlat_bit_predictor`

## Requirements
- R1: After reset every table entry predicts 2'b00, both counters read 0, and ca_valid, hit_out, mispredict and recyc_valid are low.
- R2: When base_used is 1, the table index is bits 12..19 of base_value in MSB-first numbering (bit 0 is the MSB), that is base_value[19:12]. All other bits of base_value have no effect.
- R3: When base_used is 0 and index_used is 1, the table index is index_value[19:12]. When both are 0, the index is 0.
- R4: A request presented with req_valid in one cycle shows ca_valid=1 in the next cycle. In that cycle ca_index is the selected index and ca_pred is the entry's content.
- R5: In the cache-access cycle with tlb_valid=1 and tlb_bits different from ca_pred, mispredict is 1 and hit_out is 0 even when hit_raw is 1.
- R6: After a mismatch the entry at ca_index holds tlb_bits. A later request to that index predicts those bits.
- R7: One cycle after a mismatch, recyc_valid is 1 for one cycle, with recyc_bits equal to the true bits and recyc_index equal to the slot.
- R8: When tlb_valid=1 and tlb_bits equal ca_pred, hit_out equals hit_raw, mispredict is 0, and no recycle follows.
- R9: If an entry is rewritten in the same cycle that a new request reads it, the new request's prediction is the newly written value.
- R10: good_count increments on each verified match and bad_count on each mismatch. Both saturate at all ones.
- R11: With tlb_valid=0 in the cache-access cycle there is no hit, no mispredict, no table write, no recycle and no counter change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request in address-add cycle |
| base_used | input | 1 | Request names a base register |
| base_value | input | 32 | Base register contents |
| index_used | input | 1 | Request names an index register |
| index_value | input | 32 | Index register contents |
| tlb_valid | input | 1 | Translated bits available this cache-access cycle |
| tlb_bits | input | 2 | True translated index bits |
| hit_raw | input | 1 | Directory hit computed with the predicted bits |
| ca_valid | output | 1 | Request in cache-access cycle |
| ca_pred | output | 2 | Predicted bits for cache addressing |
| ca_index | output | 8 | Table slot carried with the request |
| hit_out | output | 1 | Qualified cache hit |
| mispredict | output | 1 | Guess disagreed with translation |
| recyc_valid | output | 1 | Recycle request |
| recyc_bits | output | 2 | Correct bits for the recycle |
| recyc_index | output | 8 | Slot of the recycled request |
| good_count | output | 16 | Saturating count of correct guesses |
| bad_count | output | 16 | Saturating count of wrong guesses |

## Verification
The hardest case to reach is a table rewrite and a read of the same slot in the same edge. It needs a mispredicting request in its cache-access cycle while a second request to the same slot sits in its address-add cycle. The bench builds this by issuing back-to-back requests from one base value and forcing the first one's translated bits to differ. Counter saturation is also hard to reach at full width, so the bench builds the block with a narrow counter and runs the vector table twice.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
    localparam int DEF_ADDR_W    = 32;
    localparam int DEF_ENTRIES   = 256;
    localparam int DEF_PRED_W    = 2;
    localparam int DEF_IDX_FIRST = 12;
    localparam int DEF_CNT_W     = 16;

    typedef enum logic [1:0] {
        VR_NONE = 2'd0,
        VR_GOOD = 2'd1,
        VR_BAD  = 2'd2
    } verdict_e;
endpackage

// File: rtl/xbp_index_sel.sv
module xbp_index_sel #(
    parameter int ADDR_W    = xbp_pkg::DEF_ADDR_W,
    parameter int IDX_W     = 8,
    parameter int IDX_FIRST = xbp_pkg::DEF_IDX_FIRST
) (
    input  logic              base_used,
    input  logic [ADDR_W-1:0] base_value,
    input  logic              index_used,
    input  logic [ADDR_W-1:0] index_value,
    output logic [IDX_W-1:0]  idx
);
    localparam int HI = ADDR_W - 1 - IDX_FIRST;

    always_comb begin
        if (base_used)       idx = base_value[HI -: IDX_W];
        else if (index_used) idx = index_value[HI -: IDX_W];
        else                 idx = '0;
    end
endmodule

// File: rtl/xbp_table.sv
module xbp_table #(
    parameter int ENTRIES = xbp_pkg::DEF_ENTRIES,
    parameter int PRED_W  = xbp_pkg::DEF_PRED_W,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PRED_W-1:0] rd_bits,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PRED_W-1:0] wr_bits
);
    logic [PRED_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_bits;
        end
    end

    always_comb begin
        if (wr_en && (wr_idx == rd_idx)) rd_bits = wr_bits;
        else                             rd_bits = mem[rd_idx];
    end

    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_bits));
endmodule

// File: rtl/xbp_verify.sv
module xbp_verify #(
    parameter int PRED_W = xbp_pkg::DEF_PRED_W
) (
    input  logic              ca_valid,
    input  logic [PRED_W-1:0] ca_pred,
    input  logic              tlb_valid,
    input  logic [PRED_W-1:0] tlb_bits,
    input  logic              hit_raw,
    output logic              hit_out,
    output xbp_pkg::verdict_e verdict
);
    import xbp_pkg::*;

    logic checking;
    assign checking = ca_valid && tlb_valid;

    always_comb begin
        if (!checking)                 verdict = VR_NONE;
        else if (ca_pred == tlb_bits)  verdict = VR_GOOD;
        else                           verdict = VR_BAD;
    end

    assign hit_out = (verdict == VR_GOOD) && hit_raw;
endmodule

// File: rtl/xbp_stats.sv
module xbp_stats #(
    parameter int CNT_W = xbp_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  xbp_pkg::verdict_e verdict,
    output logic [CNT_W-1:0]  good_count,
    output logic [CNT_W-1:0]  bad_count
);
    import xbp_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            good_count <= '0;
            bad_count  <= '0;
        end else begin
            if (verdict == VR_GOOD && good_count != '1) good_count <= good_count + 1'b1;
            if (verdict == VR_BAD  && bad_count  != '1) bad_count  <= bad_count + 1'b1;
        end
    end

    p_counts_monotonic_r10: assert property (@(posedge clk) disable iff (rst)
        ##1 (good_count >= $past(good_count)) && (bad_count >= $past(bad_count)));
endmodule

// File: rtl/xlat_bit_predictor.sv
module xlat_bit_predictor #(
    parameter int ADDR_W    = xbp_pkg::DEF_ADDR_W,
    parameter int ENTRIES   = xbp_pkg::DEF_ENTRIES,
    parameter int PRED_W    = xbp_pkg::DEF_PRED_W,
    parameter int IDX_FIRST = xbp_pkg::DEF_IDX_FIRST,
    parameter int CNT_W     = xbp_pkg::DEF_CNT_W,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              base_used,
    input  logic [ADDR_W-1:0] base_value,
    input  logic              index_used,
    input  logic [ADDR_W-1:0] index_value,
    input  logic              tlb_valid,
    input  logic [PRED_W-1:0] tlb_bits,
    input  logic              hit_raw,
    output logic              ca_valid,
    output logic [PRED_W-1:0] ca_pred,
    output logic [IDX_W-1:0]  ca_index,
    output logic              hit_out,
    output logic              mispredict,
    output logic              recyc_valid,
    output logic [PRED_W-1:0] recyc_bits,
    output logic [IDX_W-1:0]  recyc_index,
    output logic [CNT_W-1:0]  good_count,
    output logic [CNT_W-1:0]  bad_count
);
    import xbp_pkg::*;

    logic [IDX_W-1:0]  aa_idx;
    logic [PRED_W-1:0] aa_bits;
    verdict_e          verdict;

    xbp_index_sel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_FIRST(IDX_FIRST)) sel_i (
        .base_used(base_used), .base_value(base_value),
        .index_used(index_used), .index_value(index_value), .idx(aa_idx));

    xbp_table #(.ENTRIES(ENTRIES), .PRED_W(PRED_W), .IDX_W(IDX_W)) tbl_i (
        .clk(clk), .rst(rst), .rd_idx(aa_idx), .rd_bits(aa_bits),
        .wr_en(mispredict), .wr_idx(ca_index), .wr_bits(tlb_bits));

    // address-add -> cache-access stage
    always_ff @(posedge clk) begin
        if (rst) begin
            ca_valid <= 1'b0;
            ca_pred  <= '0;
            ca_index <= '0;
        end else begin
            ca_valid <= req_valid;
            ca_pred  <= aa_bits;
            ca_index <= aa_idx;
        end
    end

    xbp_verify #(.PRED_W(PRED_W)) ver_i (
        .ca_valid(ca_valid), .ca_pred(ca_pred), .tlb_valid(tlb_valid),
        .tlb_bits(tlb_bits), .hit_raw(hit_raw), .hit_out(hit_out), .verdict(verdict));

    assign mispredict = (verdict == VR_BAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            recyc_valid <= 1'b0;
            recyc_bits  <= '0;
            recyc_index <= '0;
        end else begin
            recyc_valid <= mispredict;
            recyc_bits  <= tlb_bits;
            recyc_index <= ca_index;
        end
    end

    xbp_stats #(.CNT_W(CNT_W)) stats_i (
        .clk(clk), .rst(rst), .verdict(verdict),
        .good_count(good_count), .bad_count(bad_count));

    p_stage_follows_req_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ca_valid);

    p_recycle_after_miss_r7: assert property (@(posedge clk) disable iff (rst)
        mispredict |=> recyc_valid && recyc_bits == $past(tlb_bits)
                       && recyc_index == $past(ca_index));

    p_no_hit_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
        !(hit_out && mispredict));

    p_quiet_without_tlb_r11: assert property (@(posedge clk) disable iff (rst)
        !tlb_valid |=> !recyc_valid);
endmodule

// File: tb/xlat_bit_predictor_tb_top.sv
module xlat_bit_predictor_tb_top;
    localparam int CLK_NS = 20;
    localparam int CW = 3;
    localparam int SAT = (1 << CW) - 1;

    typedef struct packed {
        logic        bu;
        logic [31:0] bv;
        logic        iu;
        logic [31:0] iv;
        logic        tv;
        logic [1:0]  tb;
        logic        hr;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0003_5000, 1'b0, 32'h0000_0000, 1'b1, 2'b01, 1'b1},
        '{1'b1, 32'hFFF3_5ABC, 1'b0, 32'h0000_0000, 1'b1, 2'b01, 1'b1},
        '{1'b0, 32'h0000_0000, 1'b1, 32'h0003_5000, 1'b1, 2'b01, 1'b0},
        '{1'b1, 32'h0008_0000, 1'b1, 32'h0003_5000, 1'b1, 2'b11, 1'b1},
        '{1'b0, 32'h1234_5678, 1'b0, 32'h8765_4321, 1'b1, 2'b00, 1'b1},
        '{1'b0, 32'hABCD_EF01, 1'b0, 32'h0FF0_0FF0, 1'b1, 2'b10, 1'b1},
        '{1'b0, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b1, 2'b10, 1'b1},
        '{1'b1, 32'h0008_0000, 1'b0, 32'h0000_0000, 1'b0, 2'b00, 1'b1},
        '{1'b1, 32'h0008_0FFF, 1'b0, 32'h0000_0000, 1'b1, 2'b11, 1'b1},
        '{1'b1, 32'h000F_F000, 1'b0, 32'h0000_0000, 1'b1, 2'b10, 1'b1},
        '{1'b1, 32'h800F_F000, 1'b0, 32'h0000_0000, 1'b1, 2'b10, 1'b1}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, base_used = 0, index_used = 0;
    logic [31:0] base_value = 0, index_value = 0;
    logic tlb_valid = 0, hit_raw = 0;
    logic [1:0] tlb_bits = 0;
    logic ca_valid, hit_out, mispredict, recyc_valid;
    logic [1:0] ca_pred, recyc_bits;
    logic [7:0] ca_index, recyc_index;
    logic [CW-1:0] good_count, bad_count;

    int checks = 0, errors = 0;
    logic [1:0] ref_tbl [256];
    int ref_good = 0, ref_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    xlat_bit_predictor #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .base_used(base_used),
        .base_value(base_value), .index_used(index_used), .index_value(index_value),
        .tlb_valid(tlb_valid), .tlb_bits(tlb_bits), .hit_raw(hit_raw),
        .ca_valid(ca_valid), .ca_pred(ca_pred), .ca_index(ca_index),
        .hit_out(hit_out), .mispredict(mispredict), .recyc_valid(recyc_valid),
        .recyc_bits(recyc_bits), .recyc_index(recyc_index),
        .good_count(good_count), .bad_count(bad_count));

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_idx(input vec_t v);
        if (v.bu) return v.bv[19:12];
        if (v.iu) return v.iv[19:12];
        return 8'h00;
    endfunction

    task automatic model_verify(input logic [7:0] idx, input logic [1:0] pred, input logic [1:0] tb);
        if (pred == tb) begin
            if (ref_good < SAT) ref_good++;
        end else begin
            if (ref_bad < SAT) ref_bad++;
            ref_tbl[idx] = tb;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) ref_tbl[i] = 2'b00;
        ref_good = 0;
        ref_bad = 0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [7:0] idx;
        logic [1:0] ep;
        logic miss, hit;
        idx = ref_idx(v);
        ep  = ref_tbl[idx];
        @(negedge clk);
        req_valid = 1; base_used = v.bu; base_value = v.bv;
        index_used = v.iu; index_value = v.iv; tlb_valid = 0;
        @(negedge clk);
        req_valid = 0;
        chk(ca_valid == 1'b1, "R4 ca_valid", ca_valid, 1);
        chk(ca_index == idx, "R2/R3 index", ca_index, idx);
        chk(ca_pred == ep, "R4 pred", ca_pred, ep);
        tlb_valid = v.tv; tlb_bits = v.tb; hit_raw = v.hr;
        #1;
        miss = v.tv && (ep != v.tb);
        hit  = v.tv && (ep == v.tb) && v.hr;
        chk(hit_out == hit, miss ? "R5 hit suppress" : (v.tv ? "R8 hit pass" : "R11 no hit"), hit_out, hit);
        chk(mispredict == miss, v.tv ? "R5 mispredict" : "R11 no mispredict", mispredict, miss);
        if (v.tv) model_verify(idx, ep, v.tb);
        @(negedge clk);
        tlb_valid = 0;
        chk(recyc_valid == miss, miss ? "R7 recycle" : "R8/R11 no recycle", recyc_valid, miss);
        if (miss) begin
            chk(recyc_bits == v.tb, "R7 recyc_bits", recyc_bits, v.tb);
            chk(recyc_index == idx, "R7 recyc_index", recyc_index, idx);
        end
        chk(good_count == CW'(ref_good), "R10 good_count", good_count, ref_good);
        chk(bad_count == CW'(ref_bad), "R10 bad_count", bad_count, ref_bad);
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk(ca_valid == 0, "R1 ca_valid", ca_valid, 0);
        chk(recyc_valid == 0, "R1 recyc_valid", recyc_valid, 0);
        chk(good_count == 0 && bad_count == 0, "R1 counters", {good_count, bad_count}, 0);

        // vector table, two passes (second pass drives counter saturation, R10)
        for (int pass = 0; pass < 2; pass++)
            for (int k = 0; k < NV; k++) run_vec(VECS[k]);
        chk(good_count == CW'(SAT), "R10 saturate good", good_count, SAT);

        // R6: entry rewritten earlier now predicts the true bits
        chk(ref_tbl[8'h35] == 2'b01, "R6 model sanity", ref_tbl[8'h35], 2'b01);

        // R9: rewrite and read of the same slot in one edge
        @(negedge clk);
        req_valid = 1; base_used = 1; base_value = 32'h0004_2000; index_used = 0;
        @(negedge clk);
        chk(ca_pred == ref_tbl[8'h42], "R9 first pred", ca_pred, ref_tbl[8'h42]);
        tlb_valid = 1; tlb_bits = ~ref_tbl[8'h42]; hit_raw = 1;
        #1;
        chk(mispredict == 1'b1, "R5 bypass miss", mispredict, 1);
        model_verify(8'h42, ref_tbl[8'h42], tlb_bits);
        @(negedge clk);
        req_valid = 0;
        chk(ca_valid == 1'b1 && ca_index == 8'h42, "R9 second request", ca_index, 8'h42);
        chk(ca_pred == ref_tbl[8'h42], "R9 bypassed pred", ca_pred, ref_tbl[8'h42]);
        chk(recyc_valid == 1'b1, "R7 bypass recycle", recyc_valid, 1);
        tlb_bits = ref_tbl[8'h42]; hit_raw = 1;
        #1;
        chk(hit_out == 1'b1 && mispredict == 1'b0, "R8 bypass hit", hit_out, 1);
        model_verify(8'h42, ref_tbl[8'h42], tlb_bits);
        @(negedge clk);
        tlb_valid = 0;
        chk(recyc_valid == 1'b0, "R8 no recycle", recyc_valid, 0);

        // R1: reset clears the table
        do_reset();
        run_vec('{1'b1, 32'h0003_5000, 1'b0, 32'h0, 1'b0, 2'b00, 1'b0});
        chk(good_count == 0 && bad_count == 0, "R1 counters after reset", {good_count, bad_count}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule